// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block owns the control state of five on-chip PLLs and changes their divisors without ever letting a half-configured PLL drive its clock tree. A request names one PLL (index 0 to 4) and carries the reference divider, feedback multiplier and output divider as plain values. The block checks them against the VCO and output frequency windows, then walks the chosen PLL through a fixed order: slow mode, reset asserted, divisor fields loaded, a settle wait of a fixed time, reset released, a wait for that PLL's lock bit, and a return to normal mode. A request may instead park a PLL in deep mode, which leaves its divisors alone.

The PLL analog cores stay outside. They see the mode, reset and divisor-field outputs, and return their lock flags in one status word. A separate read port returns the frequency the selected PLL is running at, one cycle after the index is given, derived from its mode and stored fields. Requests use a valid/ready handshake and are answered by a one-cycle done pulse with an error flag; only one request is in flight at a time.

Top module: `pllseq_top`

## Requirements
- R1: A program request is rejected (done with error, no output changes) unless 440*nr <= 24*nf <= 2200*nr (VCO in MHz from a 24 MHz reference) and the output 24*nf/(nr*no) lies in 27.5..2200 MHz; both bounds are inclusive.
- R2: An output divider no other than 1 or an even value is rejected.
- R3: A request with nr outside 1..64, nf outside 1..8192, no outside 1..16, or a PLL index above 4 is rejected.
- R4: Before reset is asserted the PLL's mode is slow (0); a PLL is never in reset while in normal mode (1), and its divisor fields change only while its reset output is high.
- R5: The reset output stays high for at least SETTLE_US microseconds of clock cycles (1250 cycles by default) after the divisor fields are loaded.
- R6: Fields are stored minus one: reference divider nr-1 (6 bits), output divider no-1 (4 bits), multiplier nf-1 (13 bits); the bandwidth field (12 bits) holds nf/2-1 with nf/2 rounded down. PLL g's fields sit at bit offset g times the field width of each flattened output.
- R7: PLL g's lock flag is bit 5+g of the status word; a PLL enters normal mode only after its lock flag is seen high, and then done is signalled without error.
- R8: If the lock flag stays low for LOCK_WAIT_CYC cycles after reset release, the request ends with error, the PLL stays in slow mode with reset low.
- R9: Rate readback (one cycle latency) gives 24000000 Hz in slow mode, 32768 Hz in deep mode (mode 2 or 3), and (24*nf/(nr*no) truncated to whole MHz) times 1000000 in normal mode; an index above 4 reads 0.
- R10: A deep-park request sets the PLL's mode to 2 without touching its fields or reset and ignores the divisors; only the index is checked.
- R11: Ready is low from acceptance until done; at most one PLL is in reset at any time and PLLs other than the addressed one are left unchanged.
- R12: After reset every PLL is in slow mode with reset low and all fields zero, and ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle and able to accept |
| req_pll | input | 3 | PLL index, 0..4 |
| req_nr | input | 7 | Reference divider value |
| req_nf | input | 14 | Feedback multiplier value |
| req_no | input | 5 | Output divider value |
| req_deep | input | 1 | Park the PLL in deep mode instead of programming |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Error flag, valid with rsp_done |
| lock_sts | input | 16 | Status word, lock of PLL g at bit 5+g |
| pll_mode | output | 10 | Mode per PLL, 2 bits each |
| pll_reset | output | 5 | Reset per PLL |
| pll_nr_m1 | output | 30 | Reference divider field per PLL |
| pll_no_m1 | output | 20 | Output divider field per PLL |
| pll_nf_m1 | output | 65 | Multiplier field per PLL |
| pll_bwadj | output | 60 | Bandwidth field per PLL |
| rd_pll | input | 3 | Readback PLL index |
| rd_rate_hz | output | 32 | Readback rate in Hz |

## Verification
The assertions take for granted that a lock flag only rises while the PLL's reset is low and stays up until reset is asserted again, and that requests are only presented while ready is high. The stimulus models each PLL's lock as rising a few cycles after reset release and dropping during reset, and can hold one PLL's lock low to force the timeout. Requests are issued one at a time after the previous done, with random divisors drawn around the legal windows plus directed values sitting exactly on each bound.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

    localparam int NUM_PLL   = 5;
    localparam int IDX_W     = 3;
    localparam int NR_FW     = 6;
    localparam int NO_FW     = 4;
    localparam int NF_FW     = 13;
    localparam int BW_FW     = 12;
    localparam int NR_IW     = NR_FW + 1;
    localparam int NO_IW     = NO_FW + 1;
    localparam int NF_IW     = NF_FW + 1;
    localparam int MODE_W    = 2;
    localparam int STS_W     = 16;
    localparam int LOCK_BASE = 5;
    localparam int RATE_W    = 32;

    localparam int OSC_MHZ      = 24;
    localparam int VCO_MIN_MHZ  = 440;
    localparam int VCO_MAX_MHZ  = 2200;
    localparam int OUT_MAX_MHZ  = 2200;
    localparam int OUT_MIN_HALF = 55;   // 27.5 MHz counted in half-MHz steps
    localparam logic [RATE_W-1:0] SLOW_HZ = 32'd24000000;
    localparam logic [RATE_W-1:0] DEEP_HZ = 32'd32768;

    typedef enum logic [MODE_W-1:0] {
        MODE_SLOW   = 2'd0,
        MODE_NORMAL = 2'd1,
        MODE_DEEP   = 2'd2
    } pll_mode_e;

    typedef struct packed {
        logic [NR_FW-1:0] nr_m1;
        logic [NO_FW-1:0] no_m1;
        logic [NF_FW-1:0] nf_m1;
        logic [BW_FW-1:0] bwadj;
    } pll_fields_t;

    typedef struct packed {
        logic [IDX_W-1:0] pll;
        logic [NR_IW-1:0] nr;
        logic [NF_IW-1:0] nf;
        logic [NO_IW-1:0] no;
        logic             deep;
    } pll_req_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_SLOW, ST_RST, ST_LOAD, ST_SETTLE,
        ST_REL, ST_LOCK, ST_DEEP, ST_RESP
    } seq_state_e;

    function automatic pll_fields_t encode_fields(pll_req_t r);
        pll_fields_t f;
        f.nr_m1 = NR_FW'(r.nr - 1'b1);
        f.no_m1 = NO_FW'(r.no - 1'b1);
        f.nf_m1 = NF_FW'(r.nf - 1'b1);
        f.bwadj = BW_FW'((r.nf >> 1) - 1'b1);
        return f;
    endfunction

endpackage

// File: rtl/pllseq_check.sv
module pllseq_check
    import pllseq_pkg::*;
(
    input  pll_req_t req,
    output logic     legal
);
    logic [31:0] nr, nf, no;
    logic        idx_ok, span_ok, par_ok, vco_ok, out_ok;

    always_comb begin
        nr      = 32'(req.nr);
        nf      = 32'(req.nf);
        no      = 32'(req.no);
        idx_ok  = 32'(req.pll) < NUM_PLL;
        span_ok = (nr != 0) && (nr <= (32'd1 << NR_FW)) &&
                  (nf != 0) && (nf <= (32'd1 << NF_FW)) &&
                  (no != 0) && (no <= (32'd1 << NO_FW));
        par_ok  = (no == 32'd1) || !no[0];
        vco_ok  = (32'(OSC_MHZ) * nf >= 32'(VCO_MIN_MHZ) * nr) &&
                  (32'(OSC_MHZ) * nf <= 32'(VCO_MAX_MHZ) * nr);
        out_ok  = (32'(2 * OSC_MHZ) * nf >= 32'(OUT_MIN_HALF) * nr * no) &&
                  (32'(OSC_MHZ) * nf <= 32'(OUT_MAX_MHZ) * nr * no);
        legal   = idx_ok && (req.deep || (span_ok && par_ok && vco_ok && out_ok));
    end
endmodule

// File: rtl/pllseq_ctrl.sv
module pllseq_ctrl
    import pllseq_pkg::*;
#(
    parameter int SETTLE_CYC    = 1250,
    parameter int LOCK_WAIT_CYC = 2000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  pll_req_t         req,
    input  logic             legal,
    input  logic [STS_W-1:0] lock_sts,
    output logic             rsp_done,
    output logic             rsp_err,
    output logic [IDX_W-1:0] tgt,
    output logic             mode_we,
    output pll_mode_e        mode_val,
    output logic             rst_set,
    output logic             rst_clr,
    output logic             load_we,
    output pll_fields_t      load_val
);
    localparam int MAXC  = (SETTLE_CYC > LOCK_WAIT_CYC) ? SETTLE_CYC : LOCK_WAIT_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);

    seq_state_e       state;
    pll_req_t         cur;
    logic             err_q;
    logic [CNT_W-1:0] cnt;
    logic [STS_W-1:0] sts_sh;
    logic             lock_hit;

    always_comb begin
        sts_sh   = lock_sts >> (LOCK_BASE + int'(cur.pll));
        lock_hit = sts_sh[0];
        tgt      = cur.pll;
        req_ready = (state == ST_IDLE);
        rsp_done = (state == ST_RESP);
        rsp_err  = err_q;
        rst_set  = (state == ST_RST);
        rst_clr  = (state == ST_REL);
        load_we  = (state == ST_LOAD);
        load_val = encode_fields(cur);
        mode_we  = (state == ST_SLOW) || (state == ST_DEEP) ||
                   ((state == ST_LOCK) && lock_hit);
        if (state == ST_LOCK) mode_val = MODE_NORMAL;
        else if (cur.deep)    mode_val = MODE_DEEP;
        else                  mode_val = MODE_SLOW;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cur   <= '0;
            err_q <= 1'b0;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    cur   <= req;
                    err_q <= !legal;
                    if (!legal)        state <= ST_RESP;
                    else if (req.deep) state <= ST_DEEP;
                    else               state <= ST_SLOW;
                end
                ST_SLOW: state <= ST_RST;
                ST_RST:  state <= ST_LOAD;
                ST_LOAD: begin
                    cnt   <= '0;
                    state <= ST_SETTLE;
                end
                ST_SETTLE: begin
                    if (cnt == CNT_W'(SETTLE_CYC - 1)) state <= ST_REL;
                    else cnt <= cnt + 1'b1;
                end
                ST_REL: begin
                    cnt   <= '0;
                    state <= ST_LOCK;
                end
                ST_LOCK: begin
                    if (lock_hit) begin
                        err_q <= 1'b0;
                        state <= ST_RESP;
                    end else if (cnt == CNT_W'(LOCK_WAIT_CYC - 1)) begin
                        err_q <= 1'b1;
                        state <= ST_RESP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DEEP: state <= ST_RESP;
                ST_RESP: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8: the lock wait never runs past its window
    assert_lock_window_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOCK) |-> (cnt < CNT_W'(LOCK_WAIT_CYC)));

    // R11: a finished request leaves the block idle
    assert_ready_after_done_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> req_ready);
endmodule

// File: rtl/pllseq_rate.sv
module pllseq_rate
    import pllseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_ok,
    input  pll_mode_e         mode,
    input  pll_fields_t       fld,
    output logic [RATE_W-1:0] rate_hz
);
    logic [31:0] nr, nf, no, mhz;
    logic [RATE_W-1:0] rate_d;

    always_comb begin
        nr  = 32'(fld.nr_m1) + 32'd1;
        nf  = 32'(fld.nf_m1) + 32'd1;
        no  = 32'(fld.no_m1) + 32'd1;
        mhz = (32'(OSC_MHZ) * nf) / (nr * no);
        if (!sel_ok)                  rate_d = '0;
        else if (mode == MODE_SLOW)   rate_d = SLOW_HZ;
        else if (mode == MODE_NORMAL) rate_d = mhz * 32'd1000000;
        else                          rate_d = DEEP_HZ;
    end

    always_ff @(posedge clk) begin
        if (rst) rate_hz <= '0;
        else     rate_hz <= rate_d;
    end

    // R9: a running PLL always reads back inside the legal output window
    assert_normal_rate_R9: assert property (@(posedge clk) disable iff (rst)
        (sel_ok && mode == MODE_NORMAL) |=>
        (rate_hz >= 32'd27000000 && rate_hz <= 32'd2200000000));
endmodule

// File: rtl/pllseq_top.sv
module pllseq_top
    import pllseq_pkg::*;
#(
    parameter int CLK_HZ        = 125000000,
    parameter int SETTLE_US     = 10,
    parameter int LOCK_WAIT_CYC = 2000
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [IDX_W-1:0]           req_pll,
    input  logic [NR_IW-1:0]           req_nr,
    input  logic [NF_IW-1:0]           req_nf,
    input  logic [NO_IW-1:0]           req_no,
    input  logic                       req_deep,
    output logic                       rsp_done,
    output logic                       rsp_err,
    input  logic [STS_W-1:0]           lock_sts,
    output logic [NUM_PLL*MODE_W-1:0]  pll_mode,
    output logic [NUM_PLL-1:0]         pll_reset,
    output logic [NUM_PLL*NR_FW-1:0]   pll_nr_m1,
    output logic [NUM_PLL*NO_FW-1:0]   pll_no_m1,
    output logic [NUM_PLL*NF_FW-1:0]   pll_nf_m1,
    output logic [NUM_PLL*BW_FW-1:0]   pll_bwadj,
    input  logic [IDX_W-1:0]           rd_pll,
    output logic [RATE_W-1:0]          rd_rate_hz
);
    localparam int SETTLE_RAW = (CLK_HZ / 1000000) * SETTLE_US;
    localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;
    localparam int HOLD_W     = $clog2(SETTLE_CYC + 4) + 1;

    pll_req_t    req;
    logic        legal;
    logic [IDX_W-1:0] tgt;
    logic        mode_we, rst_set, rst_clr, load_we;
    pll_mode_e   mode_val;
    pll_fields_t load_val;

    pll_mode_e   mode_q [NUM_PLL];
    logic        rst_q  [NUM_PLL];
    pll_fields_t fld_q  [NUM_PLL];

    assign req = '{pll: req_pll, nr: req_nr, nf: req_nf, no: req_no, deep: req_deep};

    pllseq_check u_check (.req(req), .legal(legal));

    pllseq_ctrl #(.SETTLE_CYC(SETTLE_CYC), .LOCK_WAIT_CYC(LOCK_WAIT_CYC)) u_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req(req), .legal(legal), .lock_sts(lock_sts),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .tgt(tgt),
        .mode_we(mode_we), .mode_val(mode_val), .rst_set(rst_set),
        .rst_clr(rst_clr), .load_we(load_we), .load_val(load_val)
    );

    for (genvar g = 0; g < NUM_PLL; g++) begin : g_pll
        logic             hit;
        logic [HOLD_W-1:0] hold_cnt;
        assign hit = (tgt == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                mode_q[g] <= MODE_SLOW;
                rst_q[g]  <= 1'b0;
                fld_q[g]  <= '0;
            end else if (hit) begin
                if (mode_we) mode_q[g] <= mode_val;
                if (rst_set)      rst_q[g] <= 1'b1;
                else if (rst_clr) rst_q[g] <= 1'b0;
                if (load_we) fld_q[g] <= load_val;
            end
        end

        // checker counter: cycles the reset output has been high
        always_ff @(posedge clk) begin
            if (rst || !rst_q[g])            hold_cnt <= '0;
            else if (!(&hold_cnt))           hold_cnt <= hold_cnt + 1'b1;
        end

        assign pll_mode[g*MODE_W +: MODE_W]  = mode_q[g];
        assign pll_reset[g]                  = rst_q[g];
        assign pll_nr_m1[g*NR_FW +: NR_FW]   = fld_q[g].nr_m1;
        assign pll_no_m1[g*NO_FW +: NO_FW]   = fld_q[g].no_m1;
        assign pll_nf_m1[g*NF_FW +: NF_FW]   = fld_q[g].nf_m1;
        assign pll_bwadj[g*BW_FW +: BW_FW]   = fld_q[g].bwadj;

        // R4: reset and normal mode never overlap
        assert_reset_not_normal_R4: assert property (@(posedge clk) disable iff (rst)
            rst_q[g] |-> (mode_q[g] != MODE_NORMAL));

        // R4: fields only move while reset is held
        assert_fields_held_R4: assert property (@(posedge clk) disable iff (rst)
            !rst_q[g] |=> $stable(fld_q[g]));

        // R5: reset pulse covers the settle time
        assert_settle_len_R5: assert property (@(posedge clk) disable iff (rst)
            $fell(rst_q[g]) |-> (hold_cnt >= HOLD_W'(SETTLE_CYC)));

        // R7: normal mode is entered only with the lock flag up
        assert_lock_seen_R7: assert property (@(posedge clk) disable iff (rst)
            $rose(mode_q[g] == MODE_NORMAL) |-> $past(lock_sts[LOCK_BASE + g]));
    end

    // R11: at most one PLL held in reset
    logic [NUM_PLL-1:0] rst_vec;
    always_comb for (int k = 0; k < NUM_PLL; k++) rst_vec[k] = rst_q[k];
    assert_one_in_reset_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rst_vec));

    // readback select
    logic        sel_ok;
    pll_mode_e   sel_mode;
    pll_fields_t sel_fld;
    always_comb begin
        sel_ok   = 1'b0;
        sel_mode = MODE_SLOW;
        sel_fld  = '0;
        for (int k = 0; k < NUM_PLL; k++) begin
            if (rd_pll == IDX_W'(k)) begin
                sel_ok   = 1'b1;
                sel_mode = mode_q[k];
                sel_fld  = fld_q[k];
            end
        end
    end

    pllseq_rate u_rate (
        .clk(clk), .rst(rst), .sel_ok(sel_ok), .mode(sel_mode),
        .fld(sel_fld), .rate_hz(rd_rate_hz)
    );
endmodule

// File: tb/sim_pllseq_top.sv
module sim_pllseq_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_pll = '0;
    logic [6:0]  req_nr = '0;
    logic [13:0] req_nf = '0;
    logic [4:0]  req_no = '0;
    logic        req_deep = 1'b0;
    logic        rsp_done, rsp_err;
    logic [15:0] lock_sts;
    logic [9:0]  pll_mode;
    logic [4:0]  pll_reset;
    logic [29:0] pll_nr_m1;
    logic [19:0] pll_no_m1;
    logic [64:0] pll_nf_m1;
    logic [59:0] pll_bwadj;
    logic [2:0]  rd_pll = '0;
    logic [31:0] rd_rate_hz;

    localparam int SETTLE = 1250;

    always #4 clk = ~clk;

    pllseq_top u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_pll(req_pll), .req_nr(req_nr), .req_nf(req_nf), .req_no(req_no),
        .req_deep(req_deep), .rsp_done(rsp_done), .rsp_err(rsp_err),
        .lock_sts(lock_sts), .pll_mode(pll_mode), .pll_reset(pll_reset),
        .pll_nr_m1(pll_nr_m1), .pll_no_m1(pll_no_m1), .pll_nf_m1(pll_nf_m1),
        .pll_bwadj(pll_bwadj), .rd_pll(rd_pll), .rd_rate_hz(rd_rate_hz)
    );

    int nchk = 0, nfail = 0, cyc = 0;
    int e_mode[5], e_nr[5], e_nf[5], e_no[5], e_bw[5];

    // lock model: flag rises a few cycles after reset release
    logic [4:0] lk = '0, blk = '0;
    int dl[5];
    assign lock_sts = {6'b111111, lk, 5'b11111};
    always @(negedge clk) begin
        for (int i = 0; i < 5; i++) begin
            if (pll_reset[i]) begin lk[i] = 1'b0; dl[i] = 0; end
            else if (!lk[i] && !blk[i]) begin
                dl[i] = dl[i] + 1;
                if (dl[i] > 6 + i) lk[i] = 1'b1;
            end
        end
    end

    // protocol monitor
    bit mon_on = 0;
    int m_r4 = 0, m_r5 = 0, m_r7 = 0, m_r11 = 0;
    logic [1:0]  pm[5];
    logic        pr[5];
    logic [34:0] pf[5];
    int hold[5];
    always @(negedge clk) begin
        if (mon_on) begin
            if ($countones(pll_reset) > 1) m_r11++;
            for (int i = 0; i < 5; i++) begin
                logic [1:0]  md;
                logic [34:0] fv;
                md = pll_mode[i*2 +: 2];
                fv = {pll_nr_m1[i*6 +: 6], pll_no_m1[i*4 +: 4], pll_nf_m1[i*13 +: 13], pll_bwadj[i*12 +: 12]};
                if (pll_reset[i] && md == 2'd1) m_r4++;
                if (pll_reset[i] && !pr[i] && pm[i] != 2'd0) m_r4++;
                if (fv != pf[i] && !pll_reset[i]) m_r4++;
                if (pll_reset[i]) hold[i]++;
                if (!pll_reset[i] && pr[i]) begin
                    if (hold[i] < SETTLE) m_r5++;
                    hold[i] = 0;
                end
                if (md == 2'd1 && pm[i] != 2'd1 && !lk[i]) m_r7++;
                pm[i] = md; pr[i] = pll_reset[i]; pf[i] = fv;
            end
        end
    end

    task automatic chk(bit ok, string tag, longint act, longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit f_legal(int p, int nr, int nf, int no, bit deep);
        real vco, outf;
        if (p > 4) return 0;
        if (deep) return 1;
        if (nr < 1 || nr > 64 || nf < 1 || nf > 8192 || no < 1 || no > 16) return 0;
        if (no != 1 && (no % 2) != 0) return 0;
        vco  = 24.0 * nf / nr;
        outf = vco / no;
        return vco >= 440.0 && vco <= 2200.0 && outf >= 27.5 && outf <= 2200.0;
    endfunction

    function automatic longint f_rate(int p);
        if (p > 4) return 0;
        if (e_mode[p] == 0) return 24000000;
        if (e_mode[p] == 1) return longint'((24 * e_nf[p]) / (e_nr[p] * e_no[p])) * 1000000;
        return 32768;
    endfunction

    task automatic chk_rate(int p, string tag);
        @(negedge clk); rd_pll = 3'(p);
        @(negedge clk);
        chk(rd_rate_hz == 32'(f_rate(p)), tag, rd_rate_hz, f_rate(p));
    endtask

    task automatic chk_fields(int p, string tag);
        chk(pll_nr_m1[p*6 +: 6] == 6'(e_nr[p] - 1) && pll_no_m1[p*4 +: 4] == 4'(e_no[p] - 1) &&
            pll_nf_m1[p*13 +: 13] == 13'(e_nf[p] - 1) && pll_bwadj[p*12 +: 12] == 12'(e_bw[p]) &&
            pll_mode[p*2 +: 2] == 2'(e_mode[p]) && !pll_reset[p],
            tag, pll_nf_m1[p*13 +: 13], e_nf[p] - 1);
    endtask

    task automatic run(int p, int nr, int nf, int no, bit deep, bit tmo, string tag);
        bit lg, err;
        lg = f_legal(p, nr, nf, no, deep);
        @(negedge clk);
        req_pll = 3'(p); req_nr = 7'(nr); req_nf = 14'(nf); req_no = 5'(no);
        req_deep = deep; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R11", req_ready, 0);
        while (!rsp_done) @(negedge clk);
        err = rsp_err;
        chk(err == (!lg || (tmo && !deep)), tag, err, (!lg || (tmo && !deep)));
        if (lg && p < 5) begin
            if (deep) e_mode[p] = 2;
            else begin
                e_nr[p] = nr; e_nf[p] = nf; e_no[p] = no; e_bw[p] = nf / 2 - 1;
                e_mode[p] = tmo ? 0 : 1;
            end
        end
        @(negedge clk);
        if (p < 5) chk_fields(p, tag);
        chk_rate(p, "R9");
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            nfail++;
            $display("FAIL R11 watchdog actual=%0d expected=<190000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 5; i++) begin
            e_mode[i] = 0; e_nr[i] = 1; e_nf[i] = 1; e_no[i] = 1; e_bw[i] = 0;
            dl[i] = 0; hold[i] = 0;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            pm[i] = pll_mode[i*2 +: 2]; pr[i] = pll_reset[i];
            pf[i] = {pll_nr_m1[i*6 +: 6], pll_no_m1[i*4 +: 4], pll_nf_m1[i*13 +: 13], pll_bwadj[i*12 +: 12]};
        end
        mon_on = 1;
        // R12 reset state
        chk(req_ready, "R12", req_ready, 1);
        for (int i = 0; i < 5; i++) begin
            chk_fields(i, "R12");
            chk_rate(i, "R12");
        end
        chk_rate(7, "R9");

        run(3, 2, 99, 2, 0, 0, "R6");    // 594 MHz
        run(2, 1, 50, 2, 0, 0, "R7");    // 600 MHz
        run(0, 1, 50, 3, 0, 0, "R2");    // odd divider
        run(4, 1, 18, 1, 0, 0, "R1");    // VCO 432
        run(4, 3, 55, 16, 0, 0, "R1");   // VCO 440, output 27.5
        run(0, 3, 276, 2, 0, 0, "R1");   // VCO 2208
        run(0, 3, 275, 1, 0, 0, "R1");   // VCO 2200
        run(2, 0, 50, 2, 0, 0, "R3");
        run(2, 1, 50, 0, 0, 0, "R3");
        run(2, 1, 0, 2, 0, 0, "R3");
        run(5, 1, 50, 2, 0, 0, "R3");
        run(1, 65, 2000, 1, 0, 0, "R3");
        run(1, 0, 0, 3, 1, 0, "R10");    // deep park, divisors ignored
        run(6, 1, 50, 2, 1, 0, "R10");
        run(1, 1, 75, 1, 0, 0, "R7");    // back from deep, 1800 MHz
        blk[0] = 1'b1;
        run(0, 1, 50, 2, 0, 1, "R8");
        blk[0] = 1'b0;
        run(0, 1, 50, 2, 0, 0, "R7");

        void'($urandom(32'd20240611));
        for (int n = 0; n < 40; n++) begin
            run($urandom_range(0, 5), $urandom_range(1, 6), $urandom_range(10, 300),
                $urandom_range(1, 16), ($urandom_range(0, 7) == 0), 0, "R1");
        end

        for (int i = 0; i < 5; i++) chk_rate(i, "R11");
        chk(m_r4 == 0, "R4", m_r4, 0);
        chk(m_r5 == 0, "R5", m_r5, 0);
        chk(m_r7 == 0, "R7", m_r7, 0);
        chk(m_r11 == 0, "R11", m_r11, 0);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule